// File: doc/BRIEF.md
# PWM-Synchronous ADC Trigger Selector

This block sits beside a PWM time base that serves one even/odd channel pair. Each cycle it watches six single-cycle event strobes. Four of them come from the even channel: counter at zero, counter at period, compare match while counting up, and compare match while counting down. The other two come from the odd channel: compare match while counting up and compare match while counting down. A 4-bit selection code decides which event, or which pair of events, starts an ADC conversion. When the selected event fires and triggering is armed, the block issues a one-clock start pulse to the ADC.

Arming is held in a register. It is set by an arm strobe and cleared by a disarm strobe. A sticky flag records that at least one start pulse has been issued since software last cleared it. Software clears the flag by writing 1. The PWM counter that produces the strobes and the ADC that consumes the pulse are outside this block.

Top module: `adc_trig_sel`

## Requirements
- R1: With `sel_code` = 0, an even-channel zero strobe (`ev_zero`) produces a start pulse. No other strobe does.
- R2: With `sel_code` = 1, an even-channel period strobe (`ev_period`) produces a start pulse. No other strobe does.
- R3: With `sel_code` = 2, either `ev_zero` or `ev_period` produces a start pulse. When both arrive in the same cycle, exactly one pulse results.
- R4: `sel_code` = 3 selects the even-channel compare-up strobe (`ev_even_cmp_up`). `sel_code` = 4 selects the even-channel compare-down strobe (`ev_even_cmp_dn`). Each code ignores the other direction.
- R5: `sel_code` = 8 selects the odd-channel compare-up strobe (`ev_odd_cmp_up`). `sel_code` = 9 selects the odd-channel compare-down strobe (`ev_odd_cmp_dn`). Each code ignores the other direction and all even-channel strobes.
- R6: Codes 5, 6, 7 and 10 through 15 never produce a start pulse, even when every strobe is high.
- R7: `adc_start` is registered. It is high for exactly the one clock after the cycle in which a qualifying strobe is sampled, and it returns low in the cycle after that unless another qualifying strobe arrives.
- R8: While `armed` is low, no strobe produces a pulse. `arm_set` raises `armed` at the next clock edge and `arm_clr` lowers it at the next clock edge. If both are high in the same cycle, `armed` goes low.
- R9: `trig_flag` rises on the same edge as each start pulse. It then stays high until a cycle with `flag_clr` high, and it is low on the edge after that cycle.
- R10: When a start pulse is generated in the same cycle as `flag_clr`, the flag stays set.
- R11: A change of `sel_code` applies to strobes sampled from the next clock edge onward, and the change by itself produces no pulse.
- R12: After reset, `adc_start`, `trig_flag` and `armed` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_zero | input | 1 | Even channel counter reached zero |
| ev_period | input | 1 | Even channel counter reached period |
| ev_even_cmp_up | input | 1 | Even channel compare match, counting up |
| ev_even_cmp_dn | input | 1 | Even channel compare match, counting down |
| ev_odd_cmp_up | input | 1 | Odd channel compare match, counting up |
| ev_odd_cmp_dn | input | 1 | Odd channel compare match, counting down |
| sel_code | input | 4 | Trigger condition selection code |
| arm_set | input | 1 | Strobe that arms triggering |
| arm_clr | input | 1 | Strobe that disarms triggering (wins over arm_set) |
| flag_clr | input | 1 | Write-one-to-clear for the sticky flag |
| adc_start | output | 1 | One-clock ADC conversion start pulse |
| trig_flag | output | 1 | Sticky flag: a start pulse has been issued |
| armed | output | 1 | Current arming state |

## Verification
The hardest case to reach is a clear that collides with a new trigger. A qualifying strobe and `flag_clr` must be sampled on the same edge, and the flag must already be high beforehand, so that a lost set would be visible. The stimulus first arms the block and sets the flag with an earlier pulse. It then drives a zero strobe and `flag_clr` together in one cycle. A second case drives a selection-code change in a cycle with no strobes, which shows that the change alone does not pulse. The new code is then exercised on the following cycle.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int CODE_W = 4;
  localparam int NUM_EV = 6;

  typedef enum logic [CODE_W-1:0] {
    SEL_ZERO     = 4'd0,
    SEL_PERIOD   = 4'd1,
    SEL_ZERO_PRD = 4'd2,
    SEL_EVEN_UP  = 4'd3,
    SEL_EVEN_DN  = 4'd4,
    SEL_ODD_UP   = 4'd8,
    SEL_ODD_DN   = 4'd9
  } sel_e;

  typedef struct packed {
    logic odd_dn;
    logic odd_up;
    logic even_dn;
    logic even_up;
    logic period;
    logic zero;
  } ev_t;
endpackage

// File: rtl/adc_trig_decode.sv
module adc_trig_decode
  import adc_trig_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  ev_t               ev,
  output logic              hit
);
  always_comb begin
    unique case (code)
      SEL_ZERO:     hit = ev.zero;
      SEL_PERIOD:   hit = ev.period;
      SEL_ZERO_PRD: hit = ev.zero | ev.period;
      SEL_EVEN_UP:  hit = ev.even_up;
      SEL_EVEN_DN:  hit = ev.even_dn;
      SEL_ODD_UP:   hit = ev.odd_up;
      SEL_ODD_DN:   hit = ev.odd_dn;
      default:      hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_trig_ctl.sv
module adc_trig_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_set,
  input  logic arm_clr,
  input  logic pulse_set,
  input  logic flag_clr,
  output logic armed_q,
  output logic flag_q
);
  logic armed_d;
  logic armed_ce;
  logic flag_d;
  logic flag_ce;

  // Arming: disarm wins when both strobes coincide.
  always_comb begin
    armed_ce = arm_set | arm_clr;
    armed_d  = arm_set & ~arm_clr;
  end

  // Sticky flag: a new pulse wins over a clear.
  always_comb begin
    flag_ce = pulse_set | flag_clr;
    flag_d  = pulse_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (armed_ce) armed_q <= armed_d;
      if (flag_ce)  flag_q  <= flag_d;
    end
  end

  a_r8_disarm_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_set && arm_clr) |=> !armed_q);

  a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_set && flag_clr) |=> flag_q);
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_trig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_zero,
  input  logic              ev_period,
  input  logic              ev_even_cmp_up,
  input  logic              ev_even_cmp_dn,
  input  logic              ev_odd_cmp_up,
  input  logic              ev_odd_cmp_dn,
  input  logic [CODE_W-1:0] sel_code,
  input  logic              arm_set,
  input  logic              arm_clr,
  input  logic              flag_clr,
  output logic              adc_start,
  output logic              trig_flag,
  output logic              armed
);
  ev_t  ev;
  logic sel_hit;
  logic fire;
  logic start_q;
  logic start_d;

  always_comb begin
    ev.zero    = ev_zero;
    ev.period  = ev_period;
    ev.even_up = ev_even_cmp_up;
    ev.even_dn = ev_even_cmp_dn;
    ev.odd_up  = ev_odd_cmp_up;
    ev.odd_dn  = ev_odd_cmp_dn;
  end

  adc_trig_decode u_decode (
    .code (sel_code),
    .ev   (ev),
    .hit  (sel_hit)
  );

  adc_trig_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_set   (arm_set),
    .arm_clr   (arm_clr),
    .pulse_set (fire),
    .flag_clr  (flag_clr),
    .armed_q   (armed),
    .flag_q    (trig_flag)
  );

  always_comb begin
    fire    = sel_hit & armed;
    start_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_d;
  end

  assign adc_start = start_q;

  a_r6_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> ($past(sel_code) inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd8, 4'd9}));

  a_r8_needs_armed: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> $past(armed));

  a_r7_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> $past(ev_zero | ev_period | ev_even_cmp_up | ev_even_cmp_dn
                        | ev_odd_cmp_up | ev_odd_cmp_dn));

  a_r9_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> trig_flag);

  a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig_flag) |-> $past(flag_clr));
endmodule

// File: tb/adc_trig_sel_tb.sv
module adc_trig_sel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] ev = '0;
  logic [3:0] sel_code = '0;
  logic       arm_set = 1'b0, arm_clr = 1'b0, flag_clr = 1'b0;
  logic       adc_start, trig_flag, armed;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  adc_trig_sel u_dut (
    .clk(clk), .rst_n(rst_n),
    .ev_zero(ev[0]), .ev_period(ev[1]),
    .ev_even_cmp_up(ev[2]), .ev_even_cmp_dn(ev[3]),
    .ev_odd_cmp_up(ev[4]), .ev_odd_cmp_dn(ev[5]),
    .sel_code(sel_code), .arm_set(arm_set), .arm_clr(arm_clr),
    .flag_clr(flag_clr), .adc_start(adc_start),
    .trig_flag(trig_flag), .armed(armed)
  );

  // {code[3:0], events[5:0] (odd_dn,odd_up,even_dn,even_up,period,zero), expected}
  localparam int NV = 19;
  localparam logic [10:0] VEC [NV] = '{
    {4'd0, 6'b000001, 1'b1}, {4'd0, 6'b000010, 1'b0},
    {4'd1, 6'b000010, 1'b1}, {4'd1, 6'b000001, 1'b0},
    {4'd2, 6'b000001, 1'b1}, {4'd2, 6'b000010, 1'b1},
    {4'd2, 6'b000011, 1'b1},
    {4'd3, 6'b000100, 1'b1}, {4'd3, 6'b001000, 1'b0},
    {4'd4, 6'b001000, 1'b1}, {4'd4, 6'b000100, 1'b0},
    {4'd8, 6'b010000, 1'b1}, {4'd8, 6'b000100, 1'b0},
    {4'd9, 6'b100000, 1'b1}, {4'd9, 6'b010000, 1'b0},
    {4'd5, 6'b111111, 1'b0}, {4'd7, 6'b111111, 1'b0},
    {4'd10, 6'b111111, 1'b0}, {4'd15, 6'b111111, 1'b0}
  };

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd8, 4'd9: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Drive for one cycle; the next negedge lies after the capturing posedge.
  task automatic cycle();
    @(negedge clk);
    ev = '0; arm_set = 1'b0; arm_clr = 1'b0; flag_clr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12", "adc_start in reset", adc_start, 1'b0);
    check("R12", "trig_flag in reset", trig_flag, 1'b0);
    check("R12", "armed in reset", armed, 1'b0);
    rst_n = 1'b1;
    cycle();
    check("R12", "armed after release", armed, 1'b0);

    arm_set = 1'b1; cycle();
    check("R8", "arm_set raises armed", armed, 1'b1);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      sel_code = VEC[i][10:7];
      ev = VEC[i][6:1];
      cycle();
      check(tag_of(VEC[i][10:7]), $sformatf("vector %0d", i), adc_start, VEC[i][0]);
      cycle();
    end

    // R7: one-cycle pulse
    sel_code = 4'd0; ev = 6'b000001; cycle();
    check("R7", "pulse high after event", adc_start, 1'b1);
    cycle();
    check("R7", "pulse low one cycle later", adc_start, 1'b0);

    // R9: sticky flag and clear
    check("R9", "flag still set", trig_flag, 1'b1);
    repeat (3) cycle();
    check("R9", "flag held", trig_flag, 1'b1);
    flag_clr = 1'b1; cycle();
    check("R9", "flag cleared by write one", trig_flag, 1'b0);

    // R10: set beats clear
    ev = 6'b000001; cycle();
    check("R10", "flag set by pulse", trig_flag, 1'b1);
    ev = 6'b000001; flag_clr = 1'b1; cycle();
    check("R10", "pulse with clear", adc_start, 1'b1);
    check("R10", "flag kept with clear", trig_flag, 1'b1);
    flag_clr = 1'b1; cycle();

    // R11: code change alone gives no pulse, new code effective next cycle
    sel_code = 4'd0; ev = 6'b000001; cycle();
    sel_code = 4'd9; cycle();
    check("R11", "no pulse from code change", adc_start, 1'b0);
    ev = 6'b000001; cycle();
    check("R11", "old code no longer selects", adc_start, 1'b0);
    ev = 6'b100000; cycle();
    check("R11", "new code selects", adc_start, 1'b1);
    flag_clr = 1'b1; cycle();

    // R8: disarmed ignores events; disarm wins on collision
    arm_clr = 1'b1; cycle();
    check("R8", "arm_clr lowers armed", armed, 1'b0);
    sel_code = 4'd0; ev = 6'b000001; cycle();
    check("R8", "no pulse while disarmed", adc_start, 1'b0);
    check("R8", "flag untouched while disarmed", trig_flag, 1'b0);
    arm_set = 1'b1; arm_clr = 1'b1; cycle();
    check("R8", "disarm wins over arm", armed, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule